// File: doc/BRIEF.md
# UART FIFO Control and Trigger Logic

This block is the FIFO side of one UART channel. It holds a transmit queue and a receive queue, each with its own read and write pointers and level counter, and it keeps the channel's FIFO control byte. The host loads that byte through a write port. The byte enables the FIFOs, empties either queue, stores a legacy DMA mode bit and selects the trigger levels.

A separate two-bit table register picks one of four trigger tables. Both directions always use the table that was written last. Each two-bit level field indexes into that table.

The block raises two interrupts:
- A receive-data interrupt follows the receive level.
- A latched transmit-ready interrupt fires when the transmit level drops to below the trigger. It also fires when the queue drains empty, provided the latest reload never went above the trigger.

The serial shifter is outside the block. It only pops the transmit queue, and its held character survives a queue reset.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, ctl_rdata is 0x00, both counts are 0, both interrupts are 0, both overflow flags are 0 and tbl_sel is 0.
- R2: The control readback is bit0 enable, bit3 DMA mode, bits[5:4] transmit level select and bits[7:6] receive level select; bits 1 and 2 always read 0. A write with bit0 = 0 clears only the enable bit. It leaves bits 3 to 7 unchanged and resets no FIFO.
- R3: A control write with bit0 = 1 and bit1 = 1 empties the receive queue. A write with bit0 = 1 and bit2 = 1 empties the transmit queue. In both cases the count reads 0 the cycle after the write, and tx_pop_data keeps its value.
- R4: The DMA mode bit is stored and read back. It changes no count, interrupt or trigger.
- R5: The trigger level is a lookup on table tbl_sel and the 2-bit field, with the field selecting a column. Table 0 is 1,4,8,14; table 1 is 8,16,24,28; table 2 is 8,16,32,56; table 3 is 1,16,32,56. The same table serves both directions.
- R6: rx_irq is 1 exactly while rx_count is at or above the receive trigger level. It tracks the count in the same cycle.
- R7: An accepted transmit pop (without a simultaneous push) that takes tx_count from the trigger level to one below it sets tx_irq in the next cycle.
- R8: A reload counts as "above" once a push takes tx_count from the trigger level or higher to one more. That mark is cleared when the queue drains to empty and by a transmit reset. A pop from 1 to 0 sets tx_irq only if the mark is clear.
- R9: tx_irq is cleared by isr_rd or by an accepted tx_push. If a setting event falls in the same cycle as either clear, tx_irq is set.
- R10: Each queue is first-in first-out and holds DEPTH entries. A push to a full queue is dropped and sets that queue's overflow flag, which stays set until reset.
- R11: A pop from an empty queue leaves the count and the pop data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| ctl_rdata | output | 8 | Control byte readback |
| tbl_wr | input | 1 | Trigger table select write strobe |
| tbl_wdata | input | 2 | Trigger table number |
| tbl_sel | output | 2 | Current trigger table |
| tx_push | input | 1 | Host write into transmit queue |
| tx_wdata | input | 8 | Transmit character |
| tx_pop | input | 1 | Shifter pull from transmit queue |
| tx_pop_data | output | 8 | Character held for the shifter |
| tx_count | output | 7 | Transmit level |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_push | input | 1 | Receiver write into receive queue |
| rx_wdata | input | 8 | Received character |
| rx_pop | input | 1 | Host read from receive queue |
| rx_pop_data | output | 8 | Character read by host |
| rx_count | output | 7 | Receive level |
| rx_ovf | output | 1 | Sticky receive overflow |
| isr_rd | input | 1 | Interrupt status read acknowledge |
| tx_irq | output | 1 | Transmit-ready interrupt |
| rx_irq | output | 1 | Receive-data interrupt |

## Verification
Two functions can meet in one cycle: a transmit pop that sets the interrupt, and an acknowledge (or a data write) that clears it. The bench drives isr_rd in the same cycle as the pop that drains the queue. It expects tx_irq to read 1 afterwards, and a lone acknowledge on the next cycle must then bring it to 0. A push and a pop on the same transmit cycle are also driven together; they must leave the level unchanged and deliver the oldest character.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
  // Trigger level lookup: table number, then 2-bit field.
  function automatic int unsigned trig_level(input logic [1:0] tbl, input logic [1:0] sel);
    int unsigned lv;
    case (tbl)
      2'd0: case (sel) 2'd0: lv = 1; 2'd1: lv = 4;  2'd2: lv = 8;  default: lv = 14; endcase
      2'd1: case (sel) 2'd0: lv = 8; 2'd1: lv = 16; 2'd2: lv = 24; default: lv = 28; endcase
      2'd2: case (sel) 2'd0: lv = 8; 2'd1: lv = 16; 2'd2: lv = 32; default: lv = 56; endcase
      default: case (sel) 2'd0: lv = 1; 2'd1: lv = 16; 2'd2: lv = 32; default: lv = 56; endcase
    endcase
    return lv;
  endfunction
endpackage

// File: rtl/ufc_ctl_reg.sv
module ufc_ctl_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       tbl_wr,
  input  logic [1:0] tbl_wdata,
  output logic [1:0] tbl,
  output logic [1:0] tx_sel,
  output logic [1:0] rx_sel,
  output logic       rx_clr,
  output logic       tx_clr,
  output logic [7:0] rdata
);
  logic       en_q;
  logic       dma_q;
  logic [1:0] txs_q;
  logic [1:0] rxs_q;
  logic [1:0] tbl_q;
  logic       live;

  assign live   = wr & wdata[0];
  assign rx_clr = live & wdata[1];
  assign tx_clr = live & wdata[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      dma_q <= 1'b0;
      txs_q <= 2'd0;
      rxs_q <= 2'd0;
    end else if (wr) begin
      en_q <= wdata[0];
      if (wdata[0]) begin
        dma_q <= wdata[3];
        txs_q <= wdata[5:4];
        rxs_q <= wdata[7:6];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         tbl_q <= 2'd0;
    else if (tbl_wr) tbl_q <= tbl_wdata;
  end

  assign tbl    = tbl_q;
  assign tx_sel = txs_q;
  assign rx_sel = rxs_q;
  assign rdata  = {rxs_q, txs_q, dma_q, 2'b00, en_q};
endmodule

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          ovf
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          full, empty;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push & ~full & ~clr;
  assign pop_ok  = pop & ~empty & ~clr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (pop_ok) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      ovf <= 1'b0;
    else if (push & full & ~clr)  ovf <= 1'b1;
  end

  assign count = cnt;
endmodule

// File: rtl/ufc_txirq.sv
module ufc_txirq #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic          ack,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] trig,
  output logic          irq
);
  logic above;
  logic only_pop, only_push, evt;

  assign only_pop  = pop_ok & ~push_ok;
  assign only_push = push_ok & ~pop_ok;
  assign evt = only_pop & ((count == trig) | ((count == CW'(1)) & ~above));

  always_ff @(posedge clk) begin
    if (rst || clr)                              above <= 1'b0;
    else if (only_pop && count == CW'(1))        above <= 1'b0;
    else if (only_push && count >= trig)         above <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                  irq <= 1'b0;
    else if (evt)             irq <= 1'b1;
    else if (ack || push_ok)  irq <= 1'b0;
  end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          tbl_wr,
  input  logic [1:0]    tbl_wdata,
  output logic [1:0]    tbl_sel,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_pop_data,
  output logic [CW-1:0] tx_count,
  output logic          tx_ovf,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_pop_data,
  output logic [CW-1:0] rx_count,
  output logic          rx_ovf,
  input  logic          isr_rd,
  output logic          tx_irq,
  output logic          rx_irq
);
  import ufc_pkg::*;

  logic [1:0]    tx_sel, rx_sel;
  logic          rx_clr, tx_clr;
  logic [CW-1:0] tx_trig, rx_trig;
  logic          tx_push_ok, tx_pop_ok;
  logic          rx_push_ok, rx_pop_ok;

  ufc_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .tbl_wr(tbl_wr), .tbl_wdata(tbl_wdata), .tbl(tbl_sel),
    .tx_sel(tx_sel), .rx_sel(rx_sel), .rx_clr(rx_clr), .tx_clr(tx_clr),
    .rdata(ctl_rdata)
  );

  assign tx_trig = CW'(trig_level(tbl_sel, tx_sel));
  assign rx_trig = CW'(trig_level(tbl_sel, rx_sel));

  ufc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr), .push(tx_push), .din(tx_wdata),
    .pop(tx_pop), .dout(tx_pop_data), .count(tx_count),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok), .ovf(tx_ovf)
  );

  ufc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr), .push(rx_push), .din(rx_wdata),
    .pop(rx_pop), .dout(rx_pop_data), .count(rx_count),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok), .ovf(rx_ovf)
  );

  ufc_txirq #(.CW(CW)) u_txi (
    .clk(clk), .rst(rst), .clr(tx_clr), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok),
    .ack(isr_rd), .count(tx_count), .trig(tx_trig), .irq(tx_irq)
  );

  assign rx_irq = (rx_count >= rx_trig);
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_wr,
  input logic [7:0]    cfg_wdata,
  input logic [7:0]    ctl_rdata,
  input logic          tx_pop,
  input logic [DW-1:0] tx_pop_data,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          rx_ovf,
  input logic          isr_rd,
  input logic          tx_irq,
  input logic          rx_irq
);
  // R10: level never exceeds depth
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

  // R10: overflow flag is sticky
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    rx_ovf |=> rx_ovf);

  // R3: transmit reset empties the queue
  p_tx_reset_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_wdata[0] && cfg_wdata[2]) |=> (tx_count == '0));

  // R3: transmit reset keeps the shifter character
  p_shift_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_wdata[0] && cfg_wdata[2]) |=> $stable(tx_pop_data));

  // R2: enable-off write keeps the upper fields
  p_fields_kept_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_wdata[0]) |=> (ctl_rdata[7:3] == $past(ctl_rdata[7:3])));

  // R6: empty receive queue never requests
  p_rx_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_count == '0) |-> !rx_irq);

  // R11: pop on empty holds the data
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && tx_count == '0) |=> $stable(tx_pop_data));

  // R9: acknowledge without a pop clears the interrupt
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (isr_rd && !tx_pop) |=> !tx_irq);
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .ctl_rdata(ctl_rdata),
  .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .tx_count(tx_count), .rx_count(rx_count),
  .rx_ovf(rx_ovf), .isr_rd(isr_rd), .tx_irq(tx_irq), .rx_irq(rx_irq)
);

// File: tb/tb_uart_fifo_ctl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctl;
  localparam int DW = 8;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0; logic [7:0] cfg_wdata = 0; logic [7:0] ctl_rdata;
  logic tbl_wr = 0; logic [1:0] tbl_wdata = 0; logic [1:0] tbl_sel;
  logic tx_push = 0; logic [DW-1:0] tx_wdata = 0; logic tx_pop = 0;
  logic [DW-1:0] tx_pop_data; logic [CW-1:0] tx_count; logic tx_ovf;
  logic rx_push = 0; logic [DW-1:0] rx_wdata = 0; logic rx_pop = 0;
  logic [DW-1:0] rx_pop_data; logic [CW-1:0] rx_count; logic rx_ovf;
  logic isr_rd = 0; logic tx_irq, rx_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_fifo_ctl #(.DW(DW), .DEPTH(DEPTH)) dut (.*);

  // Trigger levels by {table, field}
  localparam int LVL [16] = '{1,4,8,14, 8,16,24,28, 8,16,32,56, 1,16,32,56};

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic cfg(input logic [7:0] d);
    cfg_wr = 1; cfg_wdata = d; step; cfg_wr = 0;
  endtask

  task automatic tbl(input logic [1:0] t);
    tbl_wr = 1; tbl_wdata = t; step; tbl_wr = 0;
  endtask

  task automatic rxp(input logic [7:0] d);
    rx_push = 1; rx_wdata = d; step; rx_push = 0;
  endtask

  task automatic txp(input logic [7:0] d);
    tx_push = 1; tx_wdata = d; step; tx_push = 0;
  endtask

  task automatic txpop;
    tx_pop = 1; step; tx_pop = 0;
  endtask

  task automatic rxpop;
    rx_pop = 1; step; rx_pop = 0;
  endtask

  task automatic ack;
    isr_rd = 1; step; isr_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step;
    rst = 0;
    step;
    // R1 reset state
    check("R1 ctl_rdata", ctl_rdata, 0);
    check("R1 tx_count", tx_count, 0);
    check("R1 rx_count", rx_count, 0);
    check("R1 irqs", {tx_irq, rx_irq}, 0);
    check("R1 ovf", {tx_ovf, rx_ovf}, 0);
    check("R1 tbl_sel", tbl_sel, 0);

    // R5 R6 trigger table walk
    for (int i = 0; i < 16; i++) begin
      tbl(2'(i >> 2));
      cfg({2'(i), 2'b00, 1'b0, 1'b0, 1'b1, 1'b1});
      for (int k = 0; k < LVL[i] - 1; k++) rxp(8'(k));
      check($sformatf("R5 below level idx %0d", i), rx_irq, 0);
      rxp(8'hEE);
      check($sformatf("R6 at level idx %0d", i), rx_irq, 1);
      rxpop;
      check($sformatf("R6 drop below idx %0d", i), rx_irq, 0);
    end

    // R3 receive reset
    cfg(8'h03);
    check("R3 rx cleared", rx_count, 0);

    // R2 field layout and enable-off writes
    cfg(8'hFF);
    check("R2 readback all", ctl_rdata, 8'hF9);
    rxp(8'h11); rxp(8'h22); rxp(8'h33);
    cfg(8'h06);
    check("R2 enable off readback", ctl_rdata, 8'hF8);
    check("R2 no rx reset", rx_count, 3);

    // R4 DMA bit has no effect
    tbl(2'd0);
    cfg(8'h09);
    check("R4 dma readback", ctl_rdata, 8'h09);
    check("R4 rx count kept", rx_count, 3);
    check("R4 rx irq kept", rx_irq, 1);
    check("R4 tx irq kept", tx_irq, 0);

    // R3 R11 transmit reset keeps shifter character
    cfg(8'h01);
    txp(8'hA1); txp(8'hA2);
    txpop;
    check("R10 first out", tx_pop_data, 8'hA1);
    cfg(8'h05);
    check("R3 tx cleared", tx_count, 0);
    check("R3 shifter kept", tx_pop_data, 8'hA1);
    check("R3 bit2 reads 0", ctl_rdata, 8'h01);
    txpop;
    check("R11 empty pop data", tx_pop_data, 8'hA1);
    check("R11 empty pop count", tx_count, 0);
    txp(8'h77); txpop;
    check("R10 after reset data", tx_pop_data, 8'h77);
    check("R7 trig1 drain fires", tx_irq, 1);
    ack;
    check("R9 ack clears", tx_irq, 0);

    // R7 R8 with trigger 4
    cfg(8'h11);
    for (int k = 0; k < 6; k++) txp(8'(k));
    txpop; txpop;
    check("R7 at level no irq", tx_irq, 0);
    txpop;
    check("R7 below level fires", tx_irq, 1);
    ack;
    txpop; txpop; txpop;
    check("R8 above reload no empty irq", tx_irq, 0);
    check("R8 drained", tx_count, 0);
    txp(8'h50); txp(8'h51);
    ack;
    txpop; txpop;
    check("R8 short reload empty fires", tx_irq, 1);

    // R9 clears and same-cycle collision
    txp(8'h60);
    check("R9 push clears", tx_irq, 0);
    tx_pop = 1; isr_rd = 1; step; tx_pop = 0; isr_rd = 0;
    check("R9 set beats ack", tx_irq, 1);
    ack;
    check("R9 ack after collision", tx_irq, 0);

    // R10 simultaneous push and pop
    txp(8'h81);
    tx_push = 1; tx_wdata = 8'h82; tx_pop = 1; step; tx_push = 0; tx_pop = 0;
    check("R10 push+pop level", tx_count, 1);
    check("R10 push+pop oldest", tx_pop_data, 8'h81);

    // R10 receive overflow
    cfg(8'h03);
    for (int k = 0; k < DEPTH + 1; k++) rxp(8'(k));
    check("R10 full count", rx_count, DEPTH);
    check("R10 overflow flag", rx_ovf, 1);
    check("R10 tx overflow clear", tx_ovf, 0);
    rxpop;
    check("R10 order first", rx_pop_data, 0);
    rxpop;
    check("R10 order second", rx_pop_data, 1);
    cfg(8'h03);
    check("R10 overflow sticky", rx_ovf, 1);
    rxpop;
    check("R11 rx empty pop data", rx_pop_data, 1);
    check("R11 rx empty pop count", rx_count, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule